// File: doc/BRIEF.md
# Password Retry Lockout Controller

This block keeps count of failed password attempts on a protected memory device and decides, once per transaction, whether the requested operation may proceed. It holds an 8-bit retry limit and an 8-bit retry counter. When a transaction opens, the block compares the two registers. If the retry function is enabled and the two values are equal, the block applies a lockout. The unauthorized-access code sets how severe that lockout is. One code refuses every kind of access. Every other code still admits configuration operations while refusing reads and writes.

During a transaction that was granted, the block takes one password-check result per pulse. A mismatch advances the counter by one, modulo 256. A match clears the counter, but only when the clear-on-success option is set. Lockout fires on equality only. A counter that has been programmed above the limit therefore counts up through 255, wraps to 0 and climbs back to the limit before any lockout takes effect. Both registers can be written from a byte-wide configuration bus through separate strobes. The surrounding protocol logic uses the verdict outputs to let the transfer go ahead or to abort it.

Top module: `retry_guard`

## Requirements
- R1: After reset, the limit and counter registers read 0, and `lock_all`, `cfg_only` and `grant` are 0. A strobe on `wr_limit` or `wr_count` loads `wr_data` into the matching register, and the new value shows on `limit_q` or `count_q` after that clock edge.
- R2: On a `txn_start` edge while idle, with `retry_en`=1 and the counter different from the limit, `grant` becomes 1 and both lock flags stay 0, whatever the operation class.
- R3: During a granted transaction with `retry_en`=1, a `pw_valid` pulse with `pw_match`=0 raises the counter by one, modulo 256.
- R4: During a granted transaction with `retry_en`=1, a `pw_valid` pulse with `pw_match`=1 clears the counter when `clr_on_ok`=1 and leaves it unchanged when `clr_on_ok`=0.
- R5: With `ua_code`=2'b10 (bit 1 set, bit 0 clear), `retry_en`=1 and the counter equal to the limit at `txn_start`, `lock_all` becomes 1, `cfg_only` stays 0 and `grant` is 0 for every operation class, configuration included.
- R6: With `ua_code` set to 2'b00, 2'b01 or 2'b11, `retry_en`=1 and the counter equal to the limit at `txn_start`, `cfg_only` becomes 1 and `lock_all` stays 0. `grant` is then 1 only when `txn_op`=2'd2 (configuration) and 0 when `txn_op` is 2'd0 (read) or 2'd1 (write).
- R7: When the counter is above the limit, each mismatch still advances it, wrapping from 255 to 0. Lockout takes effect only once the counter equals the limit.
- R8: With `retry_en`=0, password results leave the counter unchanged, both lock flags stay 0 and `grant` is 1 at `txn_start`.
- R9: The verdict (`lock_all`, `cfg_only`, `grant`) is registered on the `txn_start` edge and holds steady until the `txn_end` edge, which returns all three to 0. A `txn_start` that arrives during an open transaction is ignored.
- R10: When a `wr_count` strobe and a counter increment fall in the same cycle, the written value wins.
- R11: A `pw_valid` pulse arriving while no granted transaction is open (idle, or refused by a lockout) leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retry_en | input | 1 | Enables retry counting and lockout |
| clr_on_ok | input | 1 | Clears the counter after a matching password |
| ua_code | input | 2 | Unauthorized-access code that sets lockout severity |
| txn_start | input | 1 | Pulse that opens a transaction |
| txn_op | input | 2 | Operation class: 0 read, 1 write, 2 configuration |
| txn_end | input | 1 | Pulse that closes the transaction |
| pw_valid | input | 1 | Password-check result is present |
| pw_match | input | 1 | Password matched (valid with `pw_valid`) |
| wr_data | input | 8 | Configuration write data |
| wr_limit | input | 1 | Write strobe for the limit register |
| wr_count | input | 1 | Write strobe for the counter register |
| limit_q | output | 8 | Current retry limit |
| count_q | output | 8 | Current retry counter |
| lock_all | output | 1 | All access refused for this transaction |
| cfg_only | output | 1 | Only configuration admitted for this transaction |
| grant | output | 1 | Requested operation admitted |

## Verification
Any corruption of the counter shows on `count_q` one clock after the password pulse that caused it. Because the lockout test is a strict equality, an off-by-one count turns into a wrong `grant` or a wrong lock flag at the very next `txn_start`. A verdict that is latched at the wrong moment, or that leaks through between transactions, shows up as an output change in the middle of a transaction, or as nonzero flags after `txn_end`. Either symptom appears one edge after the event that caused it.

// File: rtl/retry_pkg.sv
package retry_pkg;

    localparam int CNT_W_DEF = 8;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CFG   = 2'd2,
        OP_RSVD  = 2'd3
    } op_t;

    typedef logic [1:0] ua_t;

    // code that refuses every access once the retry budget is spent
    localparam ua_t UA_SEAL = 2'b10;

    typedef struct packed {
        logic lock_all;
        logic cfg_only;
        logic grant;
    } verdict_t;

    function automatic verdict_t judge(input logic en, input ua_t ua,
                                       input op_t op, input logic equal);
        verdict_t v;
        logic spent;
        spent      = en && equal;
        v.lock_all = spent && (ua == UA_SEAL);
        v.cfg_only = spent && (ua != UA_SEAL);
        v.grant    = !spent || (v.cfg_only && op == OP_CFG);
        return v;
    endfunction

endpackage

// File: rtl/retry_counter.sv
module retry_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         fail_evt,
    input  logic         ok_evt,
    input  logic         clr_on_ok,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (wr)
            count <= wr_data;
        else if (en && fail_evt)
            count <= count + 1'b1;
        else if (en && ok_evt && clr_on_ok)
            count <= '0;
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr |=> count == $past(wr_data)); // R10

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (en && fail_evt && !wr) |=> count == W'($past(count) + 1'b1)); // R3

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr) |=> $stable(count)); // R8

endmodule

// File: rtl/verdict_latch.sv
module verdict_latch
    import retry_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  ua_t          ua,
    input  op_t          op,
    input  logic         start,
    input  logic         stop,
    input  logic [W-1:0] count,
    input  logic [W-1:0] limit,
    output logic         active,
    output verdict_t     verdict
);

    logic     equal;
    verdict_t next_v;

    assign equal  = (count == limit);
    assign next_v = judge(en, ua, op, equal);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            verdict <= '0;
        end else if (!active && start) begin
            active  <= 1'b1;
            verdict <= next_v;
        end else if (active && stop) begin
            active  <= 1'b0;
            verdict <= '0;
        end
    end

    AST_HELD_OPEN: assert property (@(posedge clk) disable iff (rst)
        (active && !stop) |=> $stable(verdict)); // R9

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !active |-> verdict == '0); // R9

    AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(verdict.lock_all && verdict.cfg_only)); // R6

    AST_SEAL_DENY: assert property (@(posedge clk) disable iff (rst)
        verdict.lock_all |-> !verdict.grant); // R5

endmodule

// File: rtl/retry_guard.sv
module retry_guard
    import retry_pkg::*;
#(
    parameter int W = CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         retry_en,
    input  logic         clr_on_ok,
    input  logic [1:0]   ua_code,
    input  logic         txn_start,
    input  logic [1:0]   txn_op,
    input  logic         txn_end,
    input  logic         pw_valid,
    input  logic         pw_match,
    input  logic [W-1:0] wr_data,
    input  logic         wr_limit,
    input  logic         wr_count,
    output logic [W-1:0] limit_q,
    output logic [W-1:0] count_q,
    output logic         lock_all,
    output logic         cfg_only,
    output logic         grant
);

    logic     active;
    verdict_t verdict;
    logic     fail_evt;
    logic     ok_evt;

    always_ff @(posedge clk) begin
        if (rst)
            limit_q <= '0;
        else if (wr_limit)
            limit_q <= wr_data;
    end

    // password results only matter inside a transaction that was let through
    assign fail_evt = active && verdict.grant && pw_valid && !pw_match;
    assign ok_evt   = active && verdict.grant && pw_valid && pw_match;

    retry_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (retry_en),
        .fail_evt  (fail_evt),
        .ok_evt    (ok_evt),
        .clr_on_ok (clr_on_ok),
        .wr        (wr_count),
        .wr_data   (wr_data),
        .count     (count_q)
    );

    verdict_latch #(.W(W)) u_vl (
        .clk     (clk),
        .rst     (rst),
        .en      (retry_en),
        .ua      (ua_t'(ua_code)),
        .op      (op_t'(txn_op)),
        .start   (txn_start),
        .stop    (txn_end),
        .count   (count_q),
        .limit   (limit_q),
        .active  (active),
        .verdict (verdict)
    );

    assign lock_all = verdict.lock_all;
    assign cfg_only = verdict.cfg_only;
    assign grant    = verdict.grant;

    AST_PW_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (pw_valid && !grant && !wr_count) |=> $stable(count_q)); // R11

    AST_LIMIT_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr_limit |=> $stable(limit_q)); // R1

endmodule

// File: tb/sim_retry_guard.sv
module sim_retry_guard;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       retry_en = 1'b0, clr_on_ok = 1'b0;
    logic [1:0] ua_code = 2'b00, txn_op = 2'd0;
    logic       txn_start = 1'b0, txn_end = 1'b0;
    logic       pw_valid = 1'b0, pw_match = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       wr_limit = 1'b0, wr_count = 1'b0;
    logic [7:0] limit_q, count_q;
    logic       lock_all, cfg_only, grant;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    retry_guard u0 (
        .clk(clk), .rst(rst), .retry_en(retry_en), .clr_on_ok(clr_on_ok),
        .ua_code(ua_code), .txn_start(txn_start), .txn_op(txn_op),
        .txn_end(txn_end), .pw_valid(pw_valid), .pw_match(pw_match),
        .wr_data(wr_data), .wr_limit(wr_limit), .wr_count(wr_count),
        .limit_q(limit_q), .count_q(count_q), .lock_all(lock_all),
        .cfg_only(cfg_only), .grant(grant)
    );

    // fields: limit, count, en, ua, op | lock_all, cfg_only, grant
    localparam int NV = 9;
    localparam logic [23:0] VEC [NV] = '{
        {8'd5,   8'd5,   1'b1, 2'b10, 2'd0, 1'b1, 1'b0, 1'b0},
        {8'd5,   8'd5,   1'b1, 2'b10, 2'd2, 1'b1, 1'b0, 1'b0},
        {8'd5,   8'd5,   1'b1, 2'b00, 2'd0, 1'b0, 1'b1, 1'b0},
        {8'd5,   8'd5,   1'b1, 2'b01, 2'd1, 1'b0, 1'b1, 1'b0},
        {8'd5,   8'd5,   1'b1, 2'b11, 2'd2, 1'b0, 1'b1, 1'b1},
        {8'd5,   8'd4,   1'b1, 2'b10, 2'd0, 1'b0, 1'b0, 1'b1},
        {8'd5,   8'd5,   1'b0, 2'b10, 2'd1, 1'b0, 1'b0, 1'b1},
        {8'd0,   8'd0,   1'b1, 2'b00, 2'd2, 1'b0, 1'b1, 1'b1},
        {8'd255, 8'd255, 1'b1, 2'b01, 2'd0, 1'b0, 1'b1, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] lim, input logic [7:0] cnt);
        wr_data = lim; wr_limit = 1'b1; tick(); wr_limit = 1'b0;
        wr_data = cnt; wr_count = 1'b1; tick(); wr_count = 1'b0;
    endtask

    task automatic open_txn(input logic [1:0] op);
        txn_op = op; txn_start = 1'b1; tick(); txn_start = 1'b0;
    endtask

    task automatic close_txn();
        txn_end = 1'b1; tick(); txn_end = 1'b0;
    endtask

    task automatic pw(input logic m);
        pw_valid = 1'b1; pw_match = m; tick(); pw_valid = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        check("R1 limit after reset", limit_q, 0);
        check("R1 count after reset", count_q, 0);
        check("R1 flags after reset", {lock_all, cfg_only, grant}, 0);

        // table walk: R2 R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            load(VEC[i][23:16], VEC[i][15:8]);
            check("R1 limit write", limit_q, VEC[i][23:16]);
            check("R1 count write", count_q, VEC[i][15:8]);
            retry_en = VEC[i][7];
            ua_code  = VEC[i][6:5];
            open_txn(VEC[i][4:3]);
            check("R2/R5/R6/R8 lock_all", lock_all, VEC[i][2]);
            check("R2/R5/R6/R8 cfg_only", cfg_only, VEC[i][1]);
            check("R2/R5/R6/R8 grant", grant, VEC[i][0]);
            close_txn();
            check("R9 cleared at end", {lock_all, cfg_only, grant}, 0);
        end

        // R3 increments, R9 held
        retry_en = 1'b1; ua_code = 2'b00; clr_on_ok = 1'b0;
        load(8'd3, 8'd0);
        open_txn(2'd0);
        pw(1'b0);
        check("R3 count 0->1", count_q, 1);
        pw(1'b0);
        check("R3 count 1->2", count_q, 2);
        check("R9 verdict held", {lock_all, cfg_only, grant}, 3'b001);
        txn_op = 2'd1; txn_start = 1'b1; ua_code = 2'b10; tick(); txn_start = 1'b0;
        check("R9 restart ignored", {lock_all, cfg_only, grant}, 3'b001);
        ua_code = 2'b00;
        // R4 match, no clear
        pw(1'b1);
        check("R4 match keeps count", count_q, 2);
        clr_on_ok = 1'b1;
        pw(1'b1);
        check("R4 match clears count", count_q, 0);
        close_txn();

        // R7 wrap above limit
        clr_on_ok = 1'b0;
        load(8'd2, 8'd254);
        open_txn(2'd0);
        check("R7 grant above limit", grant, 1);
        pw(1'b0);
        check("R7 count 255", count_q, 255);
        pw(1'b0);
        check("R7 wrap to 0", count_q, 0);
        pw(1'b0);
        pw(1'b0);
        check("R7 climbs to limit", count_q, 2);
        close_txn();
        open_txn(2'd0);
        check("R7 cfg_only at equality", cfg_only, 1);
        check("R7 read denied at equality", grant, 0);
        // R11 refused transaction ignores pw
        pw(1'b0);
        check("R11 refused pw ignored", count_q, 2);
        close_txn();
        pw(1'b0);
        check("R11 idle pw ignored", count_q, 2);

        // R8 disabled counter frozen
        retry_en = 1'b0;
        load(8'd9, 8'd3);
        open_txn(2'd1);
        pw(1'b0);
        check("R8 count frozen", count_q, 3);
        clr_on_ok = 1'b1;
        pw(1'b1);
        check("R8 no clear when off", count_q, 3);
        close_txn();

        // R10 write beats increment
        retry_en = 1'b1;
        open_txn(2'd0);
        pw_valid = 1'b1; pw_match = 1'b0; wr_data = 8'd7; wr_count = 1'b1;
        tick();
        pw_valid = 1'b0; wr_count = 1'b0;
        check("R10 write wins", count_q, 7);
        close_txn();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule